// File: doc/BRIEF.md
# Byte-Wide Static Memory with Per-Byte Hamming Correction

This block is a synchronous memory that presents the control set of an ordinary asynchronous static RAM: active-low select, active-low write strobe and active-low output strobe, plus an address, a data-in byte and a data-out byte. A driven-data flag stands in for a three-state pad. Correction is invisible at the pins. Each write stores the byte in a data array. It also stores a short Hamming check field that is computed from that byte, in a companion array at the same address. Each read decodes the stored word and repairs any single flipped bit before the byte reaches the output. The block has no error pin and no extra strobe, so a system that expects a plain memory can use it unchanged.

All control inputs are sampled on the rising edge of the system clock. Read data appears, already corrected, in the cycle after the read request. A fault-injection port XORs a mask into the full stored word at any address. A bench can use it to flip every stored bit in turn and confirm that each single flip is repaired.

Top module: `ecc_byte_sram`

## Requirements
- R1: A rising edge with `sel_n`=0 and `wr_n`=0 stores `wdata` at `addr` together with its check bits. The level of `out_n` does not matter.
- R2: A rising edge with `sel_n`=0, `wr_n`=1 and `out_n`=0 is a read. From the next edge on, `rdata_vld`=1 and `rdata` holds the corrected byte stored at that address.
- R3: While `sel_n`=1, nothing is written, whatever `wr_n` and `wdata` are. After such an edge `rdata_vld`=0.
- R4: An edge with `sel_n`=0, `wr_n`=1 and `out_n`=1 neither reads nor writes. After it `rdata_vld`=0.
- R5: After a write edge `rdata_vld`=0.
- R6: Whenever `rdata_vld`=0, `rdata` is all zeros.
- R7: The stored word is 12 bits. Bits [7:0] hold the data byte and bits [11:8] hold check bits k=0..3. Data bit i takes the i-th Hamming position that is not a power of two (3,5,6,7,9,10,11,12). Check bit k sits at position 2^k and is the XOR of the data bits whose position has bit k set.
- R8: Flipping any single one of the 12 stored bits still returns the originally written byte on read.
- R9: The syndrome is the XOR of the positions of all set stored bits. A read inverts the data bit whose position equals a nonzero syndrome. A syndrome that equals a check-bit position (1,2,4,8) or exceeds 12 leaves the stored data byte unchanged.
- R10: A rising edge with `inj_en`=1 XORs `inj_mask` (bit layout of R7) into the stored word at `inj_addr`. This happens regardless of `sel_n`.
- R11: If a write and an injection hit the same address on one edge, the word stored is the encoded `wdata` XOR `inj_mask`. A read and an injection at the same address on one edge return the word as it was before the injection.
- R12: After reset `rdata_vld`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the output state |
| sel_n | input | 1 | Active-low select |
| out_n | input | 1 | Active-low output strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Byte to store |
| rdata | output | DATA_W | Corrected byte read out |
| rdata_vld | output | 1 | High when rdata is being driven |
| inj_en | input | 1 | Apply fault mask this edge |
| inj_addr | input | ADDR_W | Address of the word to corrupt |
| inj_mask | input | DATA_W+CHK_W | Bits of the stored word to invert |

## Verification
Fault injection can land on the same edge as a write or a read. The bench provokes both cases at one address. It writes a byte while injecting a two-bit mask there, then reads. The result must match a bench model of encoding, XOR and R9 decoding. This shows that the mask was merged into the fresh word. The bench also reads an address during the same edge as a two-bit injection into it. That read must return the clean byte, and a second read must return the damaged decode.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

   // Number of check bits a single-error-correcting code needs for dw data bits.
   function automatic int chk_bits(input int dw);
      for (int r = 1; r < 16; r++) begin
         if ((1 << r) >= dw + r + 1) return r;
      end
      return 16;
   endfunction

   // Hamming position (1-based) of data bit i: i-th non-power-of-two position.
   function automatic int data_pos(input int i);
      int n;
      n = 0;
      for (int p = 3; p < 256; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == i) return p;
            n++;
         end
      end
      return 0;
   endfunction

   // Data bits covered by check bit k.
   function automatic logic [63:0] cover_mask(input int k, input int dw);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < dw; i++) begin
         if (((data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/ecc_hamming_enc.sv
module ecc_hamming_enc
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CHK_W  = chk_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   for (genvar k = 0; k < CHK_W; k++) begin : g_chk
      localparam logic [63:0] COVER = cover_mask(k, DATA_W);
      assign chk[k] = ^(data & COVER[DATA_W-1:0]);
   end

endmodule

// File: rtl/ecc_hamming_dec.sv
module ecc_hamming_dec
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CHK_W  = chk_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [CHK_W-1:0]  chk,
   output logic [CHK_W-1:0]  syndrome,
   output logic [DATA_W-1:0] fixed
);

   for (genvar k = 0; k < CHK_W; k++) begin : g_syn
      localparam logic [63:0] COVER = cover_mask(k, DATA_W);
      assign syndrome[k] = chk[k] ^ (^(data & COVER[DATA_W-1:0]));
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int POS = data_pos(i);
      assign fixed[i] = data[i] ^ (syndrome == CHK_W'(POS));
   end

endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store #(
   parameter int ADDR_W = 8,
   parameter int WORD_W = 12,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word,
   input  logic              inj_en,
   input  logic [ADDR_W-1:0] inj_addr,
   input  logic [WORD_W-1:0] inj_mask
);

   logic [WORD_W-1:0] mem [DEPTH];
   logic              inj_hits_wr;
   logic [WORD_W-1:0] wr_merged;

   assign inj_hits_wr = inj_en && wr_en && (inj_addr == wr_addr);
   assign wr_merged   = wr_word ^ (inj_hits_wr ? inj_mask : '0);

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_merged;
      if (inj_en && !inj_hits_wr) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (rd_en) rd_word <= mem[rd_addr];
   end

endmodule

// File: rtl/ecc_byte_sram.sv
module ecc_byte_sram
   import ecc_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   localparam int CHK_W  = chk_bits(DATA_W),
   localparam int WORD_W = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              out_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld,
   input  logic              inj_en,
   input  logic [ADDR_W-1:0] inj_addr,
   input  logic [WORD_W-1:0] inj_mask
);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ecc_byte_sram: ADDR_W out of range 1..12");
   end
   if (DATA_W < 4 || DATA_W > 57) begin : g_bad_data
      $error("ecc_byte_sram: DATA_W out of range 4..57");
   end

   logic              do_wr, do_rd, rd_valid_q;
   logic [CHK_W-1:0]  wr_chk, syn;
   logic [WORD_W-1:0] rd_word;
   logic [DATA_W-1:0] fixed;

   assign do_wr = !sel_n && !wr_n;
   assign do_rd = !sel_n && wr_n && !out_n;

   ecc_hamming_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data (wdata),
      .chk  (wr_chk)
   );

   ecc_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
      .clk      (clk),
      .wr_en    (do_wr),
      .wr_addr  (addr),
      .wr_word  ({wr_chk, wdata}),
      .rd_en    (do_rd),
      .rd_addr  (addr),
      .rd_word  (rd_word),
      .inj_en   (inj_en),
      .inj_addr (inj_addr),
      .inj_mask (inj_mask)
   );

   ecc_hamming_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .data     (rd_word[DATA_W-1:0]),
      .chk      (rd_word[WORD_W-1:DATA_W]),
      .syndrome (syn),
      .fixed    (fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid_q <= 1'b0;
      else        rd_valid_q <= do_rd;
   end

   assign rdata_vld = rd_valid_q;
   assign rdata     = rd_valid_q ? fixed : '0;

   // Port-level control behaviour
   p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && wr_n && !out_n) |=> rdata_vld);
   p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> !rdata_vld);
   p_oe_high_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && wr_n && out_n) |=> !rdata_vld);
   p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && !wr_n) |=> !rdata_vld);
   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_vld |-> (rdata == '0));

   // Decoder against the raw stored word
   p_clean_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_vld && syn == '0) |-> (rdata == rd_word[DATA_W-1:0]));
   p_chk_pos_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_vld && $countones(syn) == 1) |-> (rdata == rd_word[DATA_W-1:0]));
   p_beyond_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_vld && int'(syn) > WORD_W) |-> (rdata == rd_word[DATA_W-1:0]));
   p_single_fix_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_vld && syn != '0 && $countones(syn) != 1 && int'(syn) <= WORD_W)
         |-> ($countones(rdata ^ rd_word[DATA_W-1:0]) == 1));

endmodule

// File: tb/ecc_byte_sram_bench.sv
module ecc_byte_sram_bench;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int WW = 12;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1, out_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_vld;
   logic          inj_en = 1'b0;
   logic [AW-1:0] inj_addr = '0;
   logic [WW-1:0] inj_mask = '0;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [DW-1:0] model [N];

   always #10 clk = ~clk;

   ecc_byte_sram #(.ADDR_W(AW), .DATA_W(DW)) u_ecc_byte_sram (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .out_n(out_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld),
      .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
   );

   function automatic int dpos(input int i);
      int n = 0;
      for (int p = 1; p < 64; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == i) return p;
            n++;
         end
      end
      return 0;
   endfunction

   function automatic int wpos(input int b);
      return (b < DW) ? dpos(b) : (1 << (b - DW));
   endfunction

   function automatic logic [WW-1:0] encode(input logic [DW-1:0] d);
      logic [WW-1:0] w = '0;
      w[DW-1:0] = d;
      for (int k = 0; k < 4; k++)
         for (int i = 0; i < DW; i++)
            if (d[i] && ((dpos(i) >> k) & 1) == 1) w[DW+k] = ~w[DW+k];
      return w;
   endfunction

   function automatic logic [DW-1:0] decode(input logic [WW-1:0] w);
      int s = 0;
      logic [DW-1:0] d = w[DW-1:0];
      for (int b = 0; b < WW; b++) if (w[b]) s = s ^ wpos(b);
      for (int i = 0; i < DW; i++) if (s != 0 && dpos(i) == s) d[i] = ~d[i];
      return d;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      sel_n = 1'b1; wr_n = 1'b1; out_n = 1'b1; inj_en = 1'b0;
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d, input logic oe);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b0; out_n = oe; addr = AW'(a); wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic do_read(input int a, output logic [DW-1:0] d, output logic v);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b1; out_n = 1'b0; addr = AW'(a);
      @(negedge clk);
      idle();
      d = rdata; v = rdata_vld;
   endtask

   task automatic inject(input int a, input logic [WW-1:0] m);
      @(negedge clk);
      inj_en = 1'b1; inj_addr = AW'(a); inj_mask = m;
      @(negedge clk);
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      logic v;
      idle();
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12 vld", rdata_vld, 0);
      check("R12 data", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1, R5: write every address, out_n alternating
      for (int a = 0; a < N; a++) begin
         model[a] = DW'((a * 37 + 11) & 8'hFF);
         do_write(a, model[a], a[0]);
         check("R5 vld after write", rdata_vld, 0);
         check("R6 zero when idle", rdata, 0);
      end
      // R1, R2: read back every address
      for (int a = 0; a < N; a++) begin
         do_read(a, d, v);
         check("R2 vld", v, 1);
         check("R1 R2 data", d, model[a]);
      end

      // R7: zero byte stores zero word; injecting the bench encoding must read as the byte
      for (int t = 0; t < 16; t++) begin
         logic [DW-1:0] pat = DW'(t * 17 + 3);
         do_write(7, '0, 1'b1);
         inject(7, encode(pat));
         do_read(7, d, v);
         check("R7 encoding", d, pat);
      end
      model[7] = '0;

      // R8: every single-bit flip, several addresses
      for (int a = 0; a < N; a += 37) begin
         for (int b = 0; b < WW; b++) begin
            inject(a, WW'(1) << b);
            do_read(a, d, v);
            check("R8 single flip", d, model[a]);
            inject(a, WW'(1) << b);
         end
      end

      // R9: every double flip, judged by the bench decoder model
      for (int i = 0; i < WW; i++) begin
         for (int j = i + 1; j < WW; j++) begin
            logic [WW-1:0] m = (WW'(1) << i) | (WW'(1) << j);
            inject(20, m);
            do_read(20, d, v);
            check("R9 double flip", d, decode(encode(model[20]) ^ m));
            inject(20, m);
         end
      end

      // R3: deselected write attempt has no effect
      @(negedge clk);
      sel_n = 1'b1; wr_n = 1'b0; out_n = 1'b0; addr = 8'd30; wdata = ~model[30];
      @(negedge clk);
      idle();
      check("R3 vld", rdata_vld, 0);
      do_read(30, d, v);
      check("R3 no write", d, model[30]);

      // R4: out_n high gives no drive
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b1; out_n = 1'b1; addr = 8'd30;
      @(negedge clk);
      check("R4 vld", rdata_vld, 0);
      check("R4 data zero", rdata, 0);
      idle();

      // R10: injection while selected for another address
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b0; addr = 8'd41; wdata = 8'h5A; model[41] = 8'h5A;
      inj_en = 1'b1; inj_addr = 8'd42; inj_mask = 12'h003;
      @(negedge clk);
      idle();
      do_read(42, d, v);
      check("R10 inject other addr", d, decode(encode(model[42]) ^ 12'h003));
      do_read(41, d, v);
      check("R10 neighbour write", d, 8'h5A);

      // R11: write and injection on the same address and edge
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b0; addr = 8'd50; wdata = 8'hC3;
      inj_en = 1'b1; inj_addr = 8'd50; inj_mask = 12'h00C;
      @(negedge clk);
      idle();
      do_read(50, d, v);
      check("R11 write+inject", d, decode(encode(8'hC3) ^ 12'h00C));

      // R11: read and injection on the same address and edge
      do_write(51, 8'h96, 1'b0);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b1; out_n = 1'b0; addr = 8'd51;
      inj_en = 1'b1; inj_addr = 8'd51; inj_mask = 12'h030;
      @(negedge clk);
      idle();
      check("R11 read sees old word", rdata, 8'h96);
      do_read(51, d, v);
      check("R11 later read damaged", d, decode(encode(8'h96) ^ 12'h030));

      @(negedge clk);
      check("R6 idle zero", rdata, 0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule